// File: doc/BRIEF.md
# Custom-Instruction Dispatch Arbiter

This block sits between instruction fetch and two execution targets. Every fetched word goes through a shallow predecode of its top six bits. That decode only decides where the word goes. An ordinary word goes straight to the core issue port, unchanged and in the same cycle. Three reserved opcodes do not go to the core. They are partial-set, complete-set and execute, and each one carries a microcode word address in its low 26 bits. Such an opcode starts a microcode sequencer instead.

The sequencer fetches microcode words one at a time through a request/response memory port, starting at the carried address and counting upward. It forwards each word to one of two sinks. Set-phase microcode (partial-set and complete-set) goes to the configuration port, and execute-phase microcode goes to the execution port. The sequence ends with the first word whose top bit is set. That word is still delivered. While a sequence runs, no new instruction is accepted.

A guard enforces phase order. An execute instruction that arrives before any complete-set has been accepted since reset is consumed but not dispatched, and it sets a sticky error flag.

Top module: `rcu_dispatch`

## Requirements
- R1: After reset, all outgoing valid signals and the error flag are low, and with no fetch pending and a ready core port, fetch-ready is high.
- R2: A word whose bits [31:26] are none of the three reserved opcodes is presented on the core port unchanged, in the same cycle. It is consumed exactly when the core port accepts it.
- R3: The reserved opcodes are 6'h3C (partial-set), 6'h3D (complete-set) and 6'h3E (execute). A word carrying any of them never appears on the core port.
- R4: Partial-set and complete-set read microcode from consecutive word addresses, starting at bits [25:0] of the instruction, and deliver every word in order to the configuration port only.
- R5: An execute instruction accepted after a complete-set reads microcode the same way and delivers it only to the execution port.
- R6: A sequence stops after delivering the first word with bit 31 set; no further memory request follows it.
- R7: From the cycle after a custom instruction is accepted until its last microcode word is delivered, fetch-ready stays low, so a following instruction waits.
- R8: An execute instruction accepted with no complete-set since reset is consumed and issues no memory request and no execution word. It raises the error flag, which then stays high until reset.
- R9: Each output stalled by a low ready keeps its valid high and its data unchanged, and no word is lost or repeated under back-pressure on any port.
- R10: A partial-set alone does not permit execute; only an accepted complete-set does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_valid_i | input | 1 | Fetched word available |
| fetch_word_i | input | 32 | Fetched instruction word |
| fetch_ready_o | output | 1 | Arbiter takes the fetched word this cycle |
| core_valid_o | output | 1 | Word offered to the core issue port |
| core_word_o | output | 32 | Unchanged instruction for the core |
| core_ready_i | input | 1 | Core accepts the word |
| mem_req_valid_o | output | 1 | Microcode read request |
| mem_addr_o | output | 26 | Microcode word address |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_rsp_valid_i | input | 1 | Microcode word returned |
| mem_rsp_data_i | input | 32 | Returned microcode word |
| mem_rsp_ready_o | output | 1 | Sequencer takes the returned word |
| cfg_valid_o | output | 1 | Set-phase microcode word valid |
| cfg_word_o | output | 32 | Set-phase microcode word |
| cfg_ready_i | input | 1 | Configuration sink accepts |
| exe_valid_o | output | 1 | Execute-phase microcode word valid |
| exe_word_o | output | 32 | Execute-phase microcode word |
| exe_ready_i | input | 1 | Execution sink accepts |
| err_o | output | 1 | Sticky out-of-order execute flag |

## Verification
The hardest case to reach is a sequence of several words running under stalls on the request, response and sink handshakes together, with a core word already waiting at fetch. Only then can a lost or repeated word, or a core word that slips past the sequence, become visible. The bench drives all three ready lines from different modulo patterns of the cycle count while a full eight-word block is streamed. It queues an ordinary word right behind the custom one and compares the cycle of the core handshake with the cycle of the last configuration handshake. Phase-order errors are reached by resetting and issuing execute first, then after partial-set alone, then after complete-set.

// File: rtl/rcu_dispatch_pkg.sv
package rcu_dispatch_pkg;

  typedef enum logic [1:0] {
    K_CORE = 2'd0,
    K_PSET = 2'd1,
    K_CSET = 2'd2,
    K_EXEC = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_RSP  = 2'd2,
    S_PUSH = 2'd3
  } seq_e;

endpackage

// File: rtl/rcu_predecode.sv
module rcu_predecode
  import rcu_dispatch_pkg::*;
#(
  parameter int unsigned IW      = 32,
  parameter int unsigned OPW     = 6,
  parameter logic [5:0]  OP_PSET = 6'h3C,
  parameter logic [5:0]  OP_CSET = 6'h3D,
  parameter logic [5:0]  OP_EXEC = 6'h3E
) (
  input  logic [IW-1:0]     word_i,
  output kind_e             kind_o,
  output logic [IW-OPW-1:0] addr_o
);
  localparam int unsigned AW = IW - OPW;

  logic [OPW-1:0] major;

  assign major  = word_i[IW-1:AW];
  assign addr_o = word_i[AW-1:0];

  always_comb begin
    if (major == OPW'(OP_PSET))      kind_o = K_PSET;
    else if (major == OPW'(OP_CSET)) kind_o = K_CSET;
    else if (major == OPW'(OP_EXEC)) kind_o = K_EXEC;
    else                             kind_o = K_CORE;
  end
endmodule

// File: rtl/rcu_phase_guard.sv
module rcu_phase_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cset_acc_i,
  input  logic exec_acc_i,
  output logic exec_ok_o,
  output logic err_o
);
  logic cset_seen_q, cset_seen_d, cset_en;
  logic err_q, err_d, err_en;

  always_comb begin
    cset_en     = cset_acc_i;
    cset_seen_d = 1'b1;
    err_en      = exec_acc_i && !cset_seen_q;
    err_d       = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cset_seen_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      if (cset_en) cset_seen_q <= cset_seen_d;
      if (err_en)  err_q       <= err_d;
    end
  end

  assign exec_ok_o = cset_seen_q;
  assign err_o     = err_q;

  // R8: the error flag never clears without reset
  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  // R10: permission to execute, once granted, stays
  a_r10_permit_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_ok_o |=> exec_ok_o);
endmodule

// File: rtl/rcu_ucode_seq.sv
module rcu_ucode_seq
  import rcu_dispatch_pkg::*;
#(
  parameter int unsigned IW = 32,
  parameter int unsigned AW = 26
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          tgt_exe_i,
  input  logic [AW-1:0] addr_i,
  output logic          idle_o,
  output logic          mem_req_valid_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_req_ready_i,
  input  logic          mem_rsp_valid_i,
  input  logic [IW-1:0] mem_rsp_data_i,
  output logic          mem_rsp_ready_o,
  output logic          cfg_valid_o,
  output logic [IW-1:0] cfg_word_o,
  input  logic          cfg_ready_i,
  output logic          exe_valid_o,
  output logic [IW-1:0] exe_word_o,
  input  logic          exe_ready_i
);
  localparam int unsigned END_BIT = IW - 1;

  seq_e          state_q, state_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          ptr_en;
  logic [IW-1:0] word_q;
  logic          word_en;
  logic          tgt_q, tgt_en;
  logic          out_ready;
  logic          last_push;

  assign out_ready = tgt_q ? exe_ready_i : cfg_ready_i;
  assign last_push = (state_q == S_PUSH) && out_ready && word_q[END_BIT];

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    ptr_en  = 1'b0;
    word_en = 1'b0;
    tgt_en  = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d = S_REQ;
        ptr_d   = addr_i;
        ptr_en  = 1'b1;
        tgt_en  = 1'b1;
      end
      S_REQ:  if (mem_req_ready_i) state_d = S_RSP;
      S_RSP:  if (mem_rsp_valid_i) begin
        word_en = 1'b1;
        state_d = S_PUSH;
      end
      S_PUSH: if (out_ready) begin
        if (word_q[END_BIT]) begin
          state_d = S_IDLE;
        end else begin
          state_d = S_REQ;
          ptr_d   = ptr_q + AW'(1);
          ptr_en  = 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
      word_q  <= '0;
      tgt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ptr_en)  ptr_q  <= ptr_d;
      if (word_en) word_q <= mem_rsp_data_i;
      if (tgt_en)  tgt_q  <= tgt_exe_i;
    end
  end

  assign idle_o          = (state_q == S_IDLE);
  assign mem_req_valid_o = (state_q == S_REQ);
  assign mem_addr_o      = ptr_q;
  assign mem_rsp_ready_o = (state_q == S_RSP);
  assign cfg_valid_o     = (state_q == S_PUSH) && !tgt_q;
  assign exe_valid_o     = (state_q == S_PUSH) && tgt_q;
  assign cfg_word_o      = word_q;
  assign exe_word_o      = word_q;

  // R9: stalled configuration word is held
  a_r9_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o && !cfg_ready_i |=> cfg_valid_o && $stable(cfg_word_o));

  // R9: stalled execution word is held
  a_r9_exe_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exe_valid_o && !exe_ready_i |=> exe_valid_o && $stable(exe_word_o));

  // R4: stalled memory request keeps its address
  a_r4_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_addr_o));

  // R6: delivering the flagged word ends the sequence
  a_r6_end_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_push |=> idle_o && !mem_req_valid_o);
endmodule

// File: rtl/rcu_dispatch.sv
module rcu_dispatch
  import rcu_dispatch_pkg::*;
#(
  parameter int unsigned IW      = 32,
  parameter int unsigned OPW     = 6,
  parameter logic [5:0]  OP_PSET = 6'h3C,
  parameter logic [5:0]  OP_CSET = 6'h3D,
  parameter logic [5:0]  OP_EXEC = 6'h3E,
  localparam int unsigned AW     = IW - OPW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fetch_valid_i,
  input  logic [IW-1:0] fetch_word_i,
  output logic          fetch_ready_o,
  output logic          core_valid_o,
  output logic [IW-1:0] core_word_o,
  input  logic          core_ready_i,
  output logic          mem_req_valid_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_req_ready_i,
  input  logic          mem_rsp_valid_i,
  input  logic [IW-1:0] mem_rsp_data_i,
  output logic          mem_rsp_ready_o,
  output logic          cfg_valid_o,
  output logic [IW-1:0] cfg_word_o,
  input  logic          cfg_ready_i,
  output logic          exe_valid_o,
  output logic [IW-1:0] exe_word_o,
  input  logic          exe_ready_i,
  output logic          err_o
);
  kind_e         kind;
  logic [AW-1:0] uc_addr;
  logic          seq_idle;
  logic          accept;
  logic          exec_ok;
  logic          start;
  logic          cset_acc, exec_acc;

  rcu_predecode #(
    .IW(IW), .OPW(OPW), .OP_PSET(OP_PSET), .OP_CSET(OP_CSET), .OP_EXEC(OP_EXEC)
  ) u_pdec (
    .word_i (fetch_word_i),
    .kind_o (kind),
    .addr_o (uc_addr)
  );

  assign fetch_ready_o = seq_idle && ((kind != K_CORE) || core_ready_i);
  assign core_valid_o  = fetch_valid_i && seq_idle && (kind == K_CORE);
  assign core_word_o   = fetch_word_i;
  assign accept        = fetch_valid_i && fetch_ready_o;
  assign cset_acc      = accept && (kind == K_CSET);
  assign exec_acc      = accept && (kind == K_EXEC);
  assign start         = accept && ((kind == K_PSET) || (kind == K_CSET) ||
                                    ((kind == K_EXEC) && exec_ok));

  rcu_phase_guard u_guard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cset_acc_i (cset_acc),
    .exec_acc_i (exec_acc),
    .exec_ok_o  (exec_ok),
    .err_o      (err_o)
  );

  rcu_ucode_seq #(.IW(IW), .AW(AW)) u_seq (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .start_i         (start),
    .tgt_exe_i       (kind == K_EXEC),
    .addr_i          (uc_addr),
    .idle_o          (seq_idle),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_addr_o      (mem_addr_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_data_i  (mem_rsp_data_i),
    .mem_rsp_ready_o (mem_rsp_ready_o),
    .cfg_valid_o     (cfg_valid_o),
    .cfg_word_o      (cfg_word_o),
    .cfg_ready_i     (cfg_ready_i),
    .exe_valid_o     (exe_valid_o),
    .exe_word_o      (exe_word_o),
    .exe_ready_i     (exe_ready_i)
  );

  // R7: a started sequence closes the fetch port on the next cycle
  a_r7_busy_blocks_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !fetch_ready_o);

  // R8: a refused execute issues no memory request
  a_r8_no_dispatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_acc && !exec_ok |=> !mem_req_valid_o && !exe_valid_o);

  // R3: nothing reaches the core while a sequence runs
  a_r3_core_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !core_valid_o);
endmodule

// File: tb/sim_rcu_dispatch.sv
module sim_rcu_dispatch;
  logic        clk, rst_n;
  logic        fetch_valid_i;
  logic [31:0] fetch_word_i;
  logic        fetch_ready_o;
  logic        core_valid_o;
  logic [31:0] core_word_o;
  logic        core_ready_i;
  logic        mem_req_valid_o;
  logic [25:0] mem_addr_o;
  logic        mem_req_ready_i;
  logic        mem_rsp_valid_i;
  logic [31:0] mem_rsp_data_i;
  logic        mem_rsp_ready_o;
  logic        cfg_valid_o;
  logic [31:0] cfg_word_o;
  logic        cfg_ready_i;
  logic        exe_valid_o;
  logic [31:0] exe_word_o;
  logic        exe_ready_i;
  logic        err_o;

  rcu_dispatch u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_valid_i(fetch_valid_i), .fetch_word_i(fetch_word_i), .fetch_ready_o(fetch_ready_o),
    .core_valid_o(core_valid_o), .core_word_o(core_word_o), .core_ready_i(core_ready_i),
    .mem_req_valid_o(mem_req_valid_o), .mem_addr_o(mem_addr_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i), .mem_rsp_ready_o(mem_rsp_ready_o),
    .cfg_valid_o(cfg_valid_o), .cfg_word_o(cfg_word_o), .cfg_ready_i(cfg_ready_i),
    .exe_valid_o(exe_valid_o), .exe_word_o(exe_word_o), .exe_ready_i(exe_ready_i),
    .err_o(err_o)
  );

  int total = 0, bad = 0, cyc = 0;
  bit stall = 0, done = 0;
  logic [31:0] cfg_log [64];
  logic [31:0] exe_log [64];
  logic [31:0] core_log;
  int cfg_n = 0, exe_n = 0, core_n = 0, req_n = 0;
  int last_cfg_cyc = 0, core_cyc = 0;
  bit req_taken = 0, rsp_taken = 0;
  logic [25:0] req_addr = '0;

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // microcode image: a block of eight words ends at every address with low bits 3'b111
  function automatic logic [31:0] mem_img(input logic [25:0] a);
    logic [31:0] d;
    d = 32'(a[5:0]) * 32'h0001_9E37 + 32'h0000_1234;
    return {(a[2:0] == 3'h7), d[30:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // environment: memory responder and sinks
  always @(negedge clk) begin
    if (rsp_taken) mem_rsp_valid_i = 1'b0;
    if (req_taken) begin
      mem_rsp_valid_i = 1'b1;
      mem_rsp_data_i  = mem_img(req_addr);
    end
    req_taken = 0;
    rsp_taken = 0;
    mem_req_ready_i = stall ? ((cyc % 3) != 0) : 1'b1;
    cfg_ready_i     = stall ? ((cyc % 5) < 2)  : 1'b1;
    exe_ready_i     = stall ? ((cyc % 4) == 1) : 1'b1;
    core_ready_i    = stall ? ((cyc % 2) == 0) : 1'b1;
    #5;
    if (rst_n) begin
      if (mem_req_valid_o && mem_req_ready_i) begin
        req_taken = 1; req_addr = mem_addr_o; req_n++;
      end
      if (mem_rsp_valid_i && mem_rsp_ready_o) rsp_taken = 1;
      if (cfg_valid_o && cfg_ready_i) begin
        cfg_log[cfg_n % 64] = cfg_word_o; cfg_n++; last_cfg_cyc = cyc;
      end
      if (exe_valid_o && exe_ready_i) begin
        exe_log[exe_n % 64] = exe_word_o; exe_n++;
      end
      if (core_valid_o && core_ready_i) begin
        core_log = core_word_o; core_n++; core_cyc = cyc;
      end
    end
  end

  task automatic clear_logs();
    cfg_n = 0; exe_n = 0; core_n = 0; req_n = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    fetch_valid_i = 1'b0;
    fetch_word_i = '0;
    mem_rsp_valid_i = 1'b0;
    mem_rsp_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clear_logs();
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input logic [31:0] w);
    int tries;
    tries = 0;
    @(negedge clk); #2;
    fetch_valid_i = 1'b1;
    fetch_word_i  = w;
    #1;
    while (!fetch_ready_o) begin
      @(negedge clk); #3;
      tries++;
      if (tries > 2000) begin
        chk(0, "R7 fetch never accepted", 32'(tries), 0);
        break;
      end
    end
    @(posedge clk); #1;
    fetch_valid_i = 1'b0;
  endtask

  task automatic check_seq(input bit to_exe, input logic [25:0] a, input string tag);
    int n;
    n = 8 - int'(a[2:0]);
    if (to_exe) begin
      chk(exe_n == n, {tag, " exe count"}, 32'(exe_n), 32'(n));
      chk(cfg_n == 0, {tag, " no cfg words"}, 32'(cfg_n), 0);
      for (int k = 0; k < n && k < exe_n; k++)
        chk(exe_log[k] == mem_img(a + 26'(k)), {tag, " exe word"}, exe_log[k], mem_img(a + 26'(k)));
    end else begin
      chk(cfg_n == n, {tag, " cfg count"}, 32'(cfg_n), 32'(n));
      chk(exe_n == 0, {tag, " no exe words"}, 32'(exe_n), 0);
      for (int k = 0; k < n && k < cfg_n; k++)
        chk(cfg_log[k] == mem_img(a + 26'(k)), {tag, " cfg word"}, cfg_log[k], mem_img(a + 26'(k)));
    end
    chk(req_n == n, {tag, " R6 request count"}, 32'(req_n), 32'(n));
  endtask

  initial begin
    do_reset();
    // R1 reset state
    @(negedge clk); #3;
    chk(!cfg_valid_o && !exe_valid_o && !mem_req_valid_o && !core_valid_o, "R1 valids low", 0, 0);
    chk(err_o == 0, "R1 error low", 32'(err_o), 0);
    chk(fetch_ready_o == 1, "R1 fetch ready", 32'(fetch_ready_o), 1);

    // exhaustive opcode sweep: R2 and R3 (R4, R5 on the custom ones)
    for (int op = 0; op < 64; op++) begin
      logic [31:0] w;
      w = {6'(op), 26'(op * 37 + 3)};
      clear_logs();
      issue(w);
      if (op == 6'h3C || op == 6'h3D || op == 6'h3E) begin
        wait_cyc(150);
        chk(core_n == 0, "R3 custom kept off core", 32'(core_n), 0);
        check_seq(op == 6'h3E, w[25:0], "R3 sweep");
      end else begin
        wait_cyc(2);
        chk(core_n == 1 && core_log == w, "R2 core passthrough", core_log, w);
        chk(req_n == 0, "R2 no microcode fetch", 32'(req_n), 0);
      end
    end

    // R4 R6 R9: every start offset in a block, with and without stalls
    for (int s = 0; s < 2; s++) begin
      stall = (s == 1);
      for (int a = 0; a < 8; a++) begin
        logic [25:0] ad;
        ad = 26'(8 * (a + 2) + a);
        clear_logs();
        issue({6'h3C, ad});
        wait_cyc(150);
        check_seq(0, ad, stall ? "R9 pset stalled" : "R4 pset");
      end
    end

    // R8 R10: phase order
    stall = 0;
    do_reset();
    issue({6'h3E, 26'd16});
    wait_cyc(20);
    chk(err_o == 1, "R8 error raised", 32'(err_o), 1);
    chk(exe_n == 0 && req_n == 0, "R8 execute not dispatched", 32'(exe_n + req_n), 0);
    clear_logs();
    issue({6'h3C, 26'd7});
    wait_cyc(30);
    issue({6'h3E, 26'd16});
    wait_cyc(30);
    chk(exe_n == 0, "R10 pset alone refuses execute", 32'(exe_n), 0);
    chk(err_o == 1, "R8 error sticky", 32'(err_o), 1);
    clear_logs();
    issue({6'h3D, 26'd15});
    wait_cyc(30);
    clear_logs();
    stall = 1;
    issue({6'h3E, 26'd18});
    wait_cyc(150);
    check_seq(1, 26'd18, "R5 execute after cset");
    chk(err_o == 1, "R8 error held after good execute", 32'(err_o), 1);

    // R7: core word waits behind a stalled eight-word sequence
    do_reset();
    stall = 1;
    issue({6'h3C, 26'd40});
    #2;
    chk(fetch_ready_o == 0, "R7 fetch ready low while busy", 32'(fetch_ready_o), 0);
    issue(32'h0123_4567);
    wait_cyc(2);
    chk(cfg_n == 8, "R7 sequence finished before core word", 32'(cfg_n), 8);
    chk(core_n == 1 && core_cyc > last_cfg_cyc, "R7 core after last cfg word", 32'(core_cyc), 32'(last_cfg_cyc + 1));
    chk(core_log == 32'h0123_4567, "R2 queued word unchanged", core_log, 32'h0123_4567);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule